// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a serial-peripheral-interface master driven through six word registers. A host writes a mode word that sets the character length, the bit order, the clock polarity and phase, an internal loopback path, the data alignment and a two-stage clock divider. Writing a character to the transmit register starts one transfer. When the transfer ends, the received character is placed in the receive register and a receive event is raised. Chip selects are outside the block and are driven by general-purpose outputs.

The serial clock comes from the system clock. An optional divide-by-16 stage feeds a 4-bit prescaler, and the prescaler divides by 4·(PM+1). Two event flags report that a character has arrived and that the transmit register has been taken by the shifter. Software clears each flag by writing a one to it. A level interrupt combines the flags with a mask register.

Register word addresses: mode 0, event 1, mask 2, command 3, transmit 4, receive 5. Addresses 4 and 5 read back as zero unless stated otherwise.

Top module: `spim_top`

## Requirements
- R1: After reset the mode, event and mask registers read zero, and `spi_sclk`, `spi_mosi` and `irq` are low.
- R2: With enable set, a write to address 4 sets the transmit-taken flag (event bit 8) one cycle after the write edge. The received-character flag (event bit 9) is set 1+2·L·H cycles after the write edge. L is the character length and H = 2·(PM+1)·(DIV16 ? 16 : 1) is the number of system cycles per half SCLK period.
- R3: Mode bits 23:20 hold L−1, so L runs from 1 to 16. A transfer produces exactly 2·L SCLK edges, and the receive register holds an L-bit character with the upper bits zero.
- R4: Mode bit 26 set sends the character MSB first. Cleared, the character is sent LSB first.
- R5: Mode bit 29 sets the SCLK idle level high. With mode bit 28 clear, MOSI changes only on trailing edges. With bit 28 set, MOSI changes only on leading edges.
- R6: Mode bit 30 routes the shifter's output back to its own input, and the `spi_mosi` pin stays low.
- R7: With mode bit 14 set, the character is taken from the top L bits of the transmit word and returned at bits 16+L−1:16 of the receive word. With bit 14 clear, both use the low L bits.
- R8: Event flags are cleared by writing a one to their bit. Writing a zero to a flag bit, or reading the event register, leaves the flag unchanged.
- R9: `irq` is high exactly when some event flag is set and its bit (9 or 8) is set in the mask register.
- R10: With enable (mode bit 24) clear, a write to address 4 is dropped. No transfer and no SCLK activity follow, even after enable is set again.
- R11: While enable is set, a mode write leaves the divide-by-16 bit (27) and the prescaler field (19:16) unchanged.
- R12: The command register's bit 22 has no effect: writing it starts no transfer and changes no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register word address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| irq | output | 1 | Level interrupt |

## Verification
The transmit-taken flag is due on the edge after the write edge. The received-character flag is due 2·L·H edges after that, on the same edge as the last SCLK toggle. The bench drives each write at a falling edge, then counts rising edges and samples the event register after each falling edge. It compares the first cycle each flag appears against those formulas, so both early and late flags are caught. SCLK toggles and MOSI changes are observed in the same per-cycle samples to check edge counts, edge placement and bit order. Negative tests wait a fixed 200 cycles and then confirm that no flag and no SCLK toggle appeared.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam int WORD_W   = 32;
    localparam int CHAR_MAX = 16;
    localparam int LEN_W    = $clog2(CHAR_MAX);
    localparam int EDGE_W   = LEN_W + 1;
    localparam int PM_W     = 4;
    localparam int DIV_SLOW = 16;
    localparam int DIV_SH   = $clog2(DIV_SLOW);
    localparam int HALF_W   = $clog2(2 * (1 << PM_W) * DIV_SLOW) + 1;
    localparam int REG_AW   = 3;

    // mode word bit positions
    localparam int POS_LOOP  = 30;
    localparam int POS_CINV  = 29;
    localparam int POS_CPHA  = 28;
    localparam int POS_DIV   = 27;
    localparam int POS_MSBF  = 26;
    localparam int POS_MSTR  = 25;
    localparam int POS_EN    = 24;
    localparam int POS_LEN   = 20;
    localparam int POS_PM    = 16;
    localparam int POS_ALIGN = 14;
    localparam int POS_RXA   = 16;
    // event / mask / command positions
    localparam int POS_NE    = 9;
    localparam int POS_NF    = 8;
    localparam int POS_LAST  = 22;

    localparam logic [REG_AW-1:0] A_MODE  = 3'd0;
    localparam logic [REG_AW-1:0] A_EVENT = 3'd1;
    localparam logic [REG_AW-1:0] A_MASK  = 3'd2;
    localparam logic [REG_AW-1:0] A_CMD   = 3'd3;
    localparam logic [REG_AW-1:0] A_TX    = 3'd4;
    localparam logic [REG_AW-1:0] A_RX    = 3'd5;

    typedef struct packed {
        logic             loop;
        logic             cinv;
        logic             cpha;
        logic             div16;
        logic             msbf;
        logic             mstr;
        logic             en;
        logic [LEN_W-1:0] clen;
        logic [PM_W-1:0]  pm;
        logic             align;
    } mode_t;

    function automatic mode_t mode_from_word(input logic [WORD_W-1:0] w);
        mode_t m;
        m.loop  = w[POS_LOOP];
        m.cinv  = w[POS_CINV];
        m.cpha  = w[POS_CPHA];
        m.div16 = w[POS_DIV];
        m.msbf  = w[POS_MSBF];
        m.mstr  = w[POS_MSTR];
        m.en    = w[POS_EN];
        m.clen  = w[POS_LEN +: LEN_W];
        m.pm    = w[POS_PM +: PM_W];
        m.align = w[POS_ALIGN];
        return m;
    endfunction

    function automatic logic [WORD_W-1:0] mode_to_word(input mode_t m);
        logic [WORD_W-1:0] w;
        w                  = '0;
        w[POS_LOOP]        = m.loop;
        w[POS_CINV]        = m.cinv;
        w[POS_CPHA]        = m.cpha;
        w[POS_DIV]         = m.div16;
        w[POS_MSBF]        = m.msbf;
        w[POS_MSTR]        = m.mstr;
        w[POS_EN]          = m.en;
        w[POS_LEN +: LEN_W] = m.clen;
        w[POS_PM +: PM_W]  = m.pm;
        w[POS_ALIGN]       = m.align;
        return w;
    endfunction

    // system cycles per half SCLK period
    function automatic logic [HALF_W-1:0] half_len(input logic div16, input logic [PM_W-1:0] pm);
        logic [HALF_W-1:0] b;
        b = (HALF_W'(pm) + 1'b1) << 1;
        if (div16) b = b << DIV_SH;
        return b;
    endfunction

    function automatic logic [CHAR_MAX-1:0] char_mask(input logic [LEN_W-1:0] clen);
        logic [CHAR_MAX:0] t;
        t = ((CHAR_MAX+1)'(1) << (int'(clen) + 1)) - 1'b1;
        return t[CHAR_MAX-1:0];
    endfunction

    function automatic logic [CHAR_MAX-1:0] tx_extract(input logic [WORD_W-1:0] w, input mode_t m);
        logic [WORD_W-1:0] s;
        s = m.align ? (w >> (WORD_W - 1 - int'(m.clen))) : w;
        return s[CHAR_MAX-1:0] & char_mask(m.clen);
    endfunction

    function automatic logic [WORD_W-1:0] rx_format(input logic [CHAR_MAX-1:0] rx, input logic align);
        logic [WORD_W-1:0] r;
        r = WORD_W'(rx);
        return align ? (r << POS_RXA) : r;
    endfunction
endpackage

// File: rtl/spim_clkgen.sv
module spim_clkgen
    import spim_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            div16,
    input  logic [PM_W-1:0] pm,
    output logic            tick
);
    logic [HALF_W-1:0] cnt_q;
    logic [HALF_W-1:0] last;

    assign last = half_len(div16, pm) - 1'b1;
    assign tick = run && (cnt_q == last);

    always_ff @(posedge clk) begin
        if (rst || !run)   cnt_q <= '0;
        else if (tick)     cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
    import spim_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req,
    input  logic [CHAR_MAX-1:0] tx_char,
    input  mode_t               mode,
    input  logic                tick,
    input  logic                miso_pin,
    output logic                busy,
    output logic                accept,
    output logic                done,
    output logic [CHAR_MAX-1:0] rx_char,
    output logic                sclk,
    output logic                mosi
);
    logic                busy_q, tog_q, out_q, cpha_q, msbf_q;
    logic [EDGE_W-1:0]   edge_q;
    logic [LEN_W-1:0]    i_q, clen_q;
    logic [CHAR_MAX-1:0] tx_q, rx_q, rx_next;
    logic                miso_in, sample_now;

    function automatic logic [LEN_W-1:0] pos(input logic msbf, input logic [LEN_W-1:0] clen,
                                             input logic [LEN_W-1:0] i);
        return msbf ? (clen - i) : i;
    endfunction

    assign busy       = busy_q;
    assign accept     = req && !busy_q;
    assign miso_in    = mode.loop ? out_q : miso_pin;
    assign sample_now = busy_q && tick && (tog_q == cpha_q);
    assign done       = busy_q && tick && (edge_q == {clen_q, 1'b1});
    assign sclk       = mode.cinv ^ tog_q;
    assign mosi       = mode.loop ? 1'b0 : out_q;
    assign rx_char    = rx_next;

    always_comb begin
        rx_next = rx_q;
        if (sample_now) rx_next[pos(msbf_q, clen_q, i_q)] = miso_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0; tog_q <= 1'b0; out_q <= 1'b0; cpha_q <= 1'b0; msbf_q <= 1'b0;
            edge_q <= '0; i_q <= '0; clen_q <= '0; tx_q <= '0; rx_q <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            tog_q  <= 1'b0;
            edge_q <= '0;
            i_q    <= '0;
            rx_q   <= '0;
            tx_q   <= tx_char;
            clen_q <= mode.clen;
            msbf_q <= mode.msbf;
            cpha_q <= mode.cpha;
            if (!mode.cpha) out_q <= tx_char[pos(mode.msbf, mode.clen, '0)];
        end else if (busy_q && tick) begin
            tog_q  <= ~tog_q;
            edge_q <= edge_q + 1'b1;
            rx_q   <= rx_next;
            if (tog_q == cpha_q) begin
                if (cpha_q) i_q <= i_q + 1'b1;
            end else if (cpha_q) begin
                out_q <= tx_q[pos(msbf_q, clen_q, i_q)];
            end else begin
                i_q   <= i_q + 1'b1;
                out_q <= tx_q[pos(msbf_q, clen_q, LEN_W'(i_q + 1'b1))];
            end
            if (done) busy_q <= 1'b0;
        end
    end
endmodule

// File: rtl/spim_regs.sv
module spim_regs
    import spim_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [REG_AW-1:0]   addr,
    input  logic                we,
    input  logic [WORD_W-1:0]   wdata,
    input  logic                start,
    input  logic                done,
    input  logic [CHAR_MAX-1:0] rx_char,
    output mode_t               mode_q,
    output logic                pend,
    output logic [CHAR_MAX-1:0] tx_hold,
    output logic [WORD_W-1:0]   rdata,
    output logic                ev_ne,
    output logic                ev_nf,
    output logic [1:0]          mask,
    output logic                irq
);
    mode_t               mode_wr;
    logic                ne_q, nf_q, pend_q, last_q, clr_ne, clr_nf;
    logic [1:0]          mask_q;
    logic [CHAR_MAX-1:0] tx_q, rx_q;

    always_comb begin
        mode_wr = mode_from_word(wdata);
        if (mode_q.en) begin
            mode_wr.div16 = mode_q.div16;
            mode_wr.pm    = mode_q.pm;
        end
    end

    assign clr_ne  = we && (addr == A_EVENT) && wdata[POS_NE];
    assign clr_nf  = we && (addr == A_EVENT) && wdata[POS_NF];
    assign pend    = pend_q;
    assign tx_hold = tx_q;
    assign ev_ne   = ne_q;
    assign ev_nf   = nf_q;
    assign mask    = mask_q;
    assign irq     = |({ne_q, nf_q} & mask_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0; mask_q <= '0; last_q <= 1'b0; pend_q <= 1'b0;
            ne_q <= 1'b0; nf_q <= 1'b0; tx_q <= '0; rx_q <= '0;
        end else begin
            if (we && addr == A_MODE) mode_q <= mode_wr;
            if (we && addr == A_MASK) mask_q <= {wdata[POS_NE], wdata[POS_NF]};
            if (we && addr == A_CMD)  last_q <= wdata[POS_LAST];
            if (start) pend_q <= 1'b0;
            if (we && addr == A_TX && mode_q.en) begin
                pend_q <= 1'b1;
                tx_q   <= tx_extract(wdata, mode_q);
            end
            ne_q <= (ne_q && !clr_ne) || done;
            nf_q <= (nf_q && !clr_nf) || start;
            if (done) rx_q <= rx_char;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_MODE:  rdata = mode_to_word(mode_q);
            A_EVENT: begin rdata[POS_NE] = ne_q; rdata[POS_NF] = nf_q; end
            A_MASK:  begin rdata[POS_NE] = mask_q[1]; rdata[POS_NF] = mask_q[0]; end
            A_CMD:   rdata[POS_LAST] = last_q;
            A_RX:    rdata = rx_format(rx_q, mode_q.align);
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/spim_top.sv
module spim_top
    import spim_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              irq
);
    mode_t               mode_q;
    logic                tx_pend, busy, accept, done, tick, ev_ne, ev_nf;
    logic [1:0]          mask;
    logic [CHAR_MAX-1:0] tx_hold, rx_char;

    spim_regs u_regs (
        .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
        .start(accept), .done(done), .rx_char(rx_char),
        .mode_q(mode_q), .pend(tx_pend), .tx_hold(tx_hold), .rdata(bus_rdata),
        .ev_ne(ev_ne), .ev_nf(ev_nf), .mask(mask), .irq(irq)
    );

    spim_clkgen u_clk (
        .clk(clk), .rst(rst), .run(busy), .div16(mode_q.div16), .pm(mode_q.pm), .tick(tick)
    );

    spim_shifter u_shift (
        .clk(clk), .rst(rst), .req(tx_pend && mode_q.en), .tx_char(tx_hold), .mode(mode_q),
        .tick(tick), .miso_pin(spi_miso), .busy(busy), .accept(accept), .done(done),
        .rx_char(rx_char), .sclk(spi_sclk), .mosi(spi_mosi)
    );
endmodule

// File: rtl/spim_chk.sv
module spim_chk
    import spim_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            busy,
    input logic            pend,
    input logic            en,
    input logic            cinv,
    input logic            div16,
    input logic [PM_W-1:0] pm,
    input logic            sclk,
    input logic            ne,
    input logic            nf,
    input logic [1:0]      mask,
    input logic            irq
);
    // R10
    no_start_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !busy) |=> !busy);

    // R11
    div_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en)) |-> ($stable(pm) && $stable(div16)));

    // R5
    sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sclk == cinv));

    // R2
    ne_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ne) |-> ($past(busy) && !busy));

    // R2
    start_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(pend && en));

    // R9
    irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
        ((mask == 2'b00) || (!ne && !nf)) |-> !irq);
endmodule

bind spim_top spim_chk u_chk (
    .clk(clk), .rst(rst), .busy(busy), .pend(tx_pend), .en(mode_q.en), .cinv(mode_q.cinv),
    .div16(mode_q.div16), .pm(mode_q.pm), .sclk(spi_sclk), .ne(ev_ne), .nf(ev_nf),
    .mask(mask), .irq(irq)
);

// File: tb/spim_top_tb.sv
module spim_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  addr = 3'd1;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        sclk, mosi, miso, irq;
    int          checks = 0;
    int          errors = 0;
    bit          finished = 1'b0;

    always #5 clk = ~clk;

    assign miso = ~mosi;

    spim_top u_dut (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_rdata(rdata), .spi_sclk(sclk), .spi_mosi(mosi), .spi_miso(miso), .irq(irq)
    );

    function automatic logic [31:0] mk(input bit lp, input bit ci, input bit cp, input bit dv,
                                        input bit mf, input bit en, input int clen, input int pm,
                                        input bit al);
        logic [31:0] w;
        w = '0;
        w[30] = lp; w[29] = ci; w[28] = cp; w[27] = dv; w[26] = mf; w[25] = 1'b1; w[24] = en;
        w[23:20] = clen[3:0]; w[19:16] = pm[3:0]; w[14] = al;
        return w;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; we = 1'b1; wdata = d;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0; addr = 3'd1;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
        addr = 3'd1;
    endtask

    task automatic quiet(input int n, output int toggles);
        logic ps;
        toggles = 0;
        ps = sclk;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (sclk !== ps) toggles++;
            ps = sclk;
        end
    endtask

    task automatic run_xfer(input logic [31:0] mw, input bit reconfig, input logic [31:0] data);
        bit lp, ci, cp, dv, mf, al, ps, pmo;
        int L, H, j, nfj, tg, perr;
        logic [31:0] msk, txc, rxc, ser, exps, rv;
        lp = mw[30]; ci = mw[29]; cp = mw[28]; dv = mw[27]; mf = mw[26]; al = mw[14];
        L = int'(mw[23:20]) + 1;
        H = 2 * (int'(mw[19:16]) + 1) * (dv ? 16 : 1);
        msk = (32'h1 << L) - 1;
        txc = al ? ((data >> (32 - L)) & msk) : (data & msk);
        rxc = lp ? txc : (~txc & msk);
        exps = '0;
        if (!lp)
            for (int b = 0; b < L; b++) exps = {exps[30:0], (mf ? txc[L-1-b] : txc[b])};
        if (reconfig) begin
            wr(3'd0, mw & ~(32'h1 << 24));
            wr(3'd0, mw);
        end
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd4, data);
        j = 0; nfj = -1; tg = 0; perr = 0; ser = '0;
        ps = sclk; pmo = mosi;
        while (j < 2 * L * H + 20) begin
            @(posedge clk);
            @(negedge clk);
            j++;
            if (rdata[8] && nfj < 0) nfj = j;
            if (sclk !== ps) begin
                tg++;
                if (mosi !== pmo && sclk !== (cp ? ~ci : ci)) perr++;
                if (sclk === (cp ? ci : ~ci)) ser = {ser[30:0], mosi};
            end
            ps = sclk; pmo = mosi;
            if (rdata[9]) break;
        end
        check("R2 done latency", 32'(j), 32'(1 + 2 * L * H));
        check("R2 taken flag latency", 32'(nfj), 32'd1);
        check("R3 sclk edge count", 32'(tg), 32'(2 * L));
        check("R5 mosi edge placement", 32'(perr), 32'd0);
        rd(3'd5, rv);
        check("R7 R3 receive word", rv, al ? (rxc << 16) : rxc);
        if (lp) check("R6 mosi pin idle in loopback", ser, 32'd0);
        else    check("R4 serial bit order", ser, exps);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv, m0, seed;
        int tg;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(3'd0, rv); check("R1 mode reset", rv, 32'h0);
        rd(3'd1, rv); check("R1 event reset", rv, 32'h0);
        rd(3'd2, rv); check("R1 mask reset", rv, 32'h0);
        check("R1 pins reset", {29'h0, sclk, mosi, irq}, 32'h0);

        // R3 R4 R5 R6 R7: sweep modes and lengths at the fastest clock
        seed = 32'hA5C3_96E1;
        for (int cfg = 0; cfg < 16; cfg++) begin
            for (int cl = 0; cl < 16; cl++) begin
                seed = seed * 32'd1664525 + 32'd1013904223;
                run_xfer(mk(cfg[3], cfg[2], cfg[1], 1'b0, cfg[0], 1'b1, cl, 0, cl[1] ^ cfg[0]),
                         1'b1, seed);
            end
        end

        // R2: prescaler sweep, then the divide-by-16 stage
        for (int p = 0; p < 16; p++) run_xfer(mk(0, 0, 0, 0, 1, 1, 1, p, 0), 1'b1, 32'h0000_0002);
        run_xfer(mk(0, 1, 1, 1, 1, 1, 0, 0, 0), 1'b1, 32'h1);
        run_xfer(mk(0, 0, 0, 1, 0, 1, 2, 15, 0), 1'b1, 32'h5);

        // R11 divider fields locked while enabled
        m0 = mk(0, 0, 0, 0, 1, 1, 7, 0, 0);
        wr(3'd0, m0 & ~(32'h1 << 24));
        wr(3'd0, m0);
        wr(3'd0, mk(0, 0, 0, 1, 1, 1, 7, 9, 0));
        rd(3'd0, rv); check("R11 mode readback with lock", rv, m0);
        run_xfer(m0, 1'b0, 32'h0000_00C6);

        // R8 events: write-one-to-clear, reads leave flags alone
        rd(3'd1, rv); check("R8 both flags after transfer", rv, 32'h300);
        rd(3'd1, rv); check("R8 read does not clear", rv, 32'h300);
        wr(3'd1, 32'h0); rd(3'd1, rv); check("R8 zero write keeps flags", rv, 32'h300);
        // R9 interrupt masking
        wr(3'd2, 32'h0); @(negedge clk); check("R9 irq masked", {31'h0, irq}, 32'h0);
        wr(3'd1, 32'h100); rd(3'd1, rv); check("R8 clear taken flag only", rv, 32'h200);
        wr(3'd2, 32'h100); @(negedge clk); check("R9 irq with other bit masked", {31'h0, irq}, 32'h0);
        wr(3'd2, 32'h200); @(negedge clk); check("R9 irq raised", {31'h0, irq}, 32'h1);
        wr(3'd1, 32'h200); @(negedge clk); check("R9 irq drops after clear", {31'h0, irq}, 32'h0);
        rd(3'd1, rv); check("R8 all clear", rv, 32'h0);

        // R12 command bit has no effect
        wr(3'd3, 32'h1 << 22);
        quiet(200, tg);
        rd(3'd1, rv); check("R12 no event after command write", rv, 32'h0);
        check("R12 no sclk after command write", 32'(tg), 32'd0);

        // R10 transmit write while disabled is dropped
        wr(3'd0, mk(0, 0, 0, 0, 1, 0, 7, 0, 0));
        wr(3'd4, 32'h3C);
        quiet(200, tg);
        rd(3'd1, rv); check("R10 no event while disabled", rv, 32'h0);
        check("R10 no sclk while disabled", 32'(tg), 32'd0);
        wr(3'd0, mk(0, 0, 0, 0, 1, 1, 7, 0, 0));
        quiet(100, tg);
        rd(3'd1, rv); check("R10 dropped write stays dropped", rv, 32'h0);
        check("R10 no sclk after enabling", 32'(tg), 32'd0);
        run_xfer(mk(0, 0, 0, 0, 1, 1, 7, 0, 0), 1'b0, 32'h96);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule